// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port of up to 32 pins, reached over a simple word-wide register bus. Each pin has a direction bit, a bit in an output latch, and a synchronized input sample. The pad side of the port exposes three vectors: the level to drive, an active-high drive enable, and the pin level coming back in.

Software changes the output latch through two strobe registers. One sets bits and the other clears them: a one in the written word acts on that bit, and a zero leaves it alone. Concurrent agents can therefore toggle their own pins without a read-modify-write. The latch also has a plain load-and-read view. The pad always carries the latch value, so the level can be set before a pin is turned into an output.

Pin levels pass through a multi-flop synchronizer before the input register can read them. The input register works the same whether the pin is an input or an output.

Top module: `sc_gpio_port`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every direction bit is 1, the output latch is 0, `padOe` is all zeros and `padOut` is all zeros. A read of byte offset 0x00 returns all ones.
- R2: A write to offset 0x00 (direction) loads the whole word. A direction bit of 1 makes the pin an input, with `padOe` low. A bit of 0 makes it an output, with `padOe` high, from the cycle after the write.
- R3: A write to offset 0x08 (set strobe) forces every latch bit high where the data bit is 1. Latch bits where the data bit is 0 keep their value.
- R4: A write to offset 0x0C (clear strobe) forces every latch bit low where the data bit is 1. Latch bits where the data bit is 0 keep their value.
- R5: A write to offset 0x04 loads the latch with the whole word. Reads of 0x04, 0x08 and 0x0C all return the current latch value.
- R6: A read of offset 0x10 returns `padIn` as it was two clock edges earlier, whatever the pin directions are. A write to 0x10 changes neither the latch nor the direction.
- R7: `padOut` equals the latch for every pin, whatever the direction. A value loaded while a pin is an input is driven as soon as that pin becomes an output.
- R8: Reads of offsets 0x14, 0x18 and 0x1C, and reads of any offset whose two low bits are not zero, return 0. Writes to these offsets change nothing.
- R9: A cycle with `busSel` low, or with `busWrite` low, leaves the latch and the direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte offset of the register |
| busWdata | input | PIN_COUNT (32) | Write data |
| busRdata | output | PIN_COUNT (32) | Read data, combinational from the address |
| padIn | input | PIN_COUNT (32) | Levels seen at the pins |
| padOut | output | PIN_COUNT (32) | Level to drive on each pin |
| padOe | output | PIN_COUNT (32) | Drive enable for each pin, high = output |

## Verification
The bench builds the port with its defaults: 32 pins, a 5-bit byte address and a two-stage synchronizer. With 32 pins, the all-ones and alternating masks on the set and clear strobes cover every bit position. With two stages, the input lag can be checked cycle by cycle against a bench-side delay line. The 5-bit address leaves three unmapped word offsets, plus misaligned offsets, to probe the ignore rules.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte offsets of the registers
  localparam int OFF_DIR = 'h00;
  localparam int OFF_LAT = 'h04;
  localparam int OFF_SET = 'h08;
  localparam int OFF_CLR = 'h0C;
  localparam int OFF_IN  = 'h10;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DIR  = 2'd1,
    RD_LAT  = 2'd2,
    RD_IN   = 2'd3
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   dirWr;
    logic   latWr;
    logic   setWr;
    logic   clrWr;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);

  logic aligned;
  logic wrEn;
  logic hitDir, hitLat, hitSet, hitClr, hitIn;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrEn    = busSel && busWrite && aligned;

  assign hitDir = (busAddr == ADDR_W'(OFF_DIR));
  assign hitLat = (busAddr == ADDR_W'(OFF_LAT));
  assign hitSet = (busAddr == ADDR_W'(OFF_SET));
  assign hitClr = (busAddr == ADDR_W'(OFF_CLR));
  assign hitIn  = (busAddr == ADDR_W'(OFF_IN));

  always_comb begin
    strobes       = '0;
    strobes.dirWr = wrEn && hitDir;
    strobes.latWr = wrEn && hitLat;
    strobes.setWr = wrEn && hitSet;
    strobes.clrWr = wrEn && hitClr;
    if (hitDir)                         strobes.rdSel = RD_DIR;
    else if (hitLat || hitSet || hitClr) strobes.rdSel = RD_LAT;
    else if (hitIn)                     strobes.rdSel = RD_IN;
    else                                strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdata,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] latQ;
  logic [PIN_COUNT-1:0] setMask, clrMask;
  logic [PIN_COUNT-1:0] latNext;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dirQ <= '1;
    else if (strobes.dirWr) dirQ <= wdata;
  end

  // Clear is applied after set, so clear wins when both hit one bit.
  assign setMask = strobes.setWr ? wdata : '0;
  assign clrMask = strobes.clrWr ? wdata : '0;

  always_comb begin
    if (strobes.latWr) latNext = wdata;
    else               latNext = (latQ | setMask) & ~clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latQ <= '0;
    else       latQ <= latNext;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobes.rdSel)
      RD_DIR:  rdata = dirQ;
      RD_LAT:  rdata = latQ;
      RD_IN:   rdata = syncQ[SYNC_STAGES-1];
      default: rdata = '0;
    endcase
  end

  assign padOut = latQ;
  assign padOe  = ~dirQ;

endmodule

// File: rtl/sc_gpio_port.sv
module sc_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  ctrlStrobes_t strobes;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  gpio_port_dp #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (busWdata),
    .padIn   (padIn),
    .rdata   (busRdata),
    .padOut  (padOut),
    .padOe   (padOe)
  );

endmodule

// File: rtl/sc_gpio_port_chk.sv
module sc_gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [PIN_COUNT-1:0] busWdata,
  input logic [PIN_COUNT-1:0] busRdata,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe
);

  logic wrCyc;
  logic [1:0] upCnt;

  assign wrCyc = busSel && busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0) && (padOut == '0));

  assert_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && busAddr == ADDR_W'(OFF_DIR)) |=> padOe == ~$past(busWdata));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && busAddr == ADDR_W'(OFF_SET)) |=>
      padOut == ($past(padOut) | $past(busWdata)));

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && busAddr == ADDR_W'(OFF_CLR)) |=>
      padOut == ($past(padOut) & ~$past(busWdata)));

  assert_in_lag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (SYNC_STAGES == 2 && upCnt >= 2'd2 && busAddr == ADDR_W'(OFF_IN))
      |-> busRdata == $past(padIn, 2));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrCyc |=> $stable(padOut) && $stable(padOe));

endmodule

bind sc_gpio_port sc_gpio_port_chk #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .padIn(padIn), .padOut(padOut), .padOe(padOe)
);

// File: tb/test_sc_gpio_port.sv
`timescale 1ns/1ps
module test_sc_gpio_port;

  localparam int PW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [PW-1:0] busWdata = '0;
  logic [PW-1:0] busRdata;
  logic [PW-1:0] padIn = '0;
  logic [PW-1:0] padOut;
  logic [PW-1:0] padOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [PW-1:0] dirM, latM, syn0M, syn1M;

  always #2.5 clk = ~clk;

  sc_gpio_port i_sc_gpio_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // Two-edge delay line for the input register (R6)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin syn0M <= '0; syn1M <= '0; end
    else begin syn1M <= syn0M; syn0M <= padIn; end
  end

  function automatic logic [PW-1:0] readModel(input logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a)
      5'h00:               return dirM;
      5'h04, 5'h08, 5'h0C: return latM;
      5'h10:               return syn1M;
      default:             return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [PW-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    if (a[1:0] == 2'b00) begin
      case (a)
        5'h00: dirM = d;
        5'h04: latM = d;
        5'h08: latM = latM | d;
        5'h0C: latM = latM & ~d;
        default: ;
      endcase
    end
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic checkPads(input string req);
    check({req, " padOut"}, padOut, latM);
    check({req, " padOe"}, padOe, ~dirM);
  endtask

  task automatic busRdCheck(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    check(req, busRdata, readModel(a));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    dirM = '1; latM = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 padOe in reset", padOe, '0);
    check("R1 padOut in reset", padOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 after reset");
    busRdCheck(5'h00, "R1 dir reset read");

    // R7: preload while input, then switch to output
    busWr(5'h08, 32'h0000_00F0);
    checkPads("R7 preload");
    busWr(5'h00, 32'hFFFF_FF0F);
    checkPads("R7 drive after dir switch");
    busRdCheck(5'h00, "R2 dir read");

    // R3/R4 masks
    busWr(5'h08, 32'hFFFF_FFFF);
    checkPads("R3 set all");
    busWr(5'h0C, 32'hAAAA_AAAA);
    checkPads("R4 clear alternate");
    busWr(5'h0C, 32'h0000_0000);
    checkPads("R4 clear zero word");
    busWr(5'h08, 32'h0000_0000);
    checkPads("R3 set zero word");
    busRdCheck(5'h08, "R5 read set view");
    busRdCheck(5'h0C, "R5 read clear view");
    busWr(5'h04, 32'h1234_5678);
    busRdCheck(5'h04, "R5 latch load");

    // R6: input lag and write ignored
    @(negedge clk); padIn = 32'hCAFE_F00D;
    @(posedge clk); @(negedge clk);
    busAddr = 5'h10; #1;
    check("R6 one edge old", busRdata, 32'h0000_0000);
    @(negedge clk); #1;
    check("R6 two edges new", busRdata, 32'hCAFE_F00D);
    busWr(5'h10, 32'h5555_5555);
    checkPads("R6 write to input ignored");

    // R8 unmapped and misaligned
    busWr(5'h14, 32'hFFFF_FFFF);
    busWr(5'h19, 32'h0000_0000);
    busWr(5'h01, 32'h0000_0000);
    checkPads("R8 unmapped writes");
    busRdCheck(5'h18, "R8 unmapped read");
    busRdCheck(5'h1C, "R8 unmapped read");
    busRdCheck(5'h05, "R8 misaligned read");

    // R9: busWrite high without busSel, busSel with read
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b1; busAddr = 5'h04; busWdata = 32'hDEAD_BEEF;
    @(negedge clk);
    busWrite = 1'b0; busSel = 1'b1; busAddr = 5'h00;
    @(negedge clk);
    busSel = 1'b0;
    checkPads("R9 no write strobe");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [PW-1:0] d;
      logic [AW-1:0] a;
      op = $urandom_range(0, 5);
      d  = $urandom;
      a  = AW'($urandom_range(0, 31));
      case (op)
        0: busWr(5'h00, d);
        1: busWr(5'h08, d);
        2: busWr(5'h0C, d);
        3: busWr(5'h04, d);
        4: busWr(a, d);
        default: begin @(negedge clk); padIn = d; end
      endcase
      checkPads("R3 R4 R5 R2 random");
      busRdCheck(a, "R5 R6 R8 random read");
      busRdCheck(5'h10, "R6 random input read");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule